// File: doc/BRIEF.md
# Dual-Edge PDM Microphone Receiver

This block captures up to four pulse-density-modulated microphones that share one PDM clock and two data lines. On each line, one microphone drives its bit while the clock is low and is sampled as the clock rises. A second microphone drives its bit while the clock is high and is sampled as the clock falls. The block always generates the PDM clock itself, dividing the core clock by a parameter (16 by default) with a 50 % duty cycle.

A route word selects a source for each of the four logical channels. For channel n, one bit picks the clock edge and another bit picks the data line. This lets any microphone feed any channel, and several channels may share one source. An enable bit per channel gates its output. Once per PDM clock period, each enabled channel presents one bit with a one-cycle valid strobe and its channel number. The decimation filters downstream consume these outputs.

Top module: `pdm_dual_edge_rx`

## Requirements
- R1: While reset is asserted, `pdm_clk_o`, every `ch_vld_o` bit, every `ch_bit_o` bit and every `ch_tag_o` field are 0.
- R2: `pdm_clk_o` has a period of CLK_DIV core cycles. After reset it is low for the first CLK_DIV/2 cycles and high for the next CLK_DIV/2 cycles, and this pattern repeats.
- R3: The rising-edge slot of a line is the value present in the core cycle just before `pdm_clk_o` rises. The falling-edge slot is the value present in the core cycle just before it falls.
- R4: Bit 2n of `cfg_route_i` selects the edge for channel n (0 = rising slot, 1 = falling slot). Bit 2n+16 selects the line (0 = `pdm_dat_i[0]`, 1 = `pdm_dat_i[1]`).
- R5: The two slots captured in PDM period k are delivered in the first core cycle of the high phase of period k+1. `ch_vld_o` is high for that single cycle only.
- R6: Channels routed to the same line and edge deliver identical bits in the same cycle.
- R7: While `cfg_en_i[n]` is 0, `ch_vld_o[n]` and `ch_bit_o[n]` stay 0.
- R8: The enables are sampled in the core cycle before `pdm_clk_o` rises. A channel enabled before that cycle delivers a valid bit at the very next strobe, with no start-up delay.
- R9: `ch_tag_o[2n+1:2n]` equals n while `ch_vld_o[n]` is high and 0 otherwise. `ch_bit_o[n]` is 0 whenever `ch_vld_o[n]` is 0.
- R10: Bits of `cfg_route_i` other than bits 2n and 2n+16 (n = 0..3) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdm_dat_i | input | 2 | PDM data lines, each shared by two microphones |
| cfg_en_i | input | 4 | Per-channel capture enable |
| cfg_route_i | input | 24 | Edge select at bits 2n, line select at bits 2n+16 |
| pdm_clk_o | output | 1 | Generated PDM clock |
| ch_bit_o | output | 4 | One PDM bit per channel |
| ch_vld_o | output | 4 | Per-channel one-cycle valid strobe |
| ch_tag_o | output | 8 | Two-bit channel number per channel |

## Verification
If the divider drifts out of phase, the strobe moves away from the rising edge of `pdm_clk_o`. This is visible within one PDM period. A capture register loaded on the wrong edge, or a crossbar select taken from the wrong route bit, swaps rising and falling or line 0 and line 1 data. With pseudo-random line data, such a fault shows up as a bit mismatch at the next strobe, one period after the bad sample. An enable or tag fault shows up in the same strobe cycle in which the faulty channel is expected.

// File: rtl/pdmfe_pkg.sv
`timescale 1ns/1ps
package pdmfe_pkg;
  localparam int unsigned LINES         = 2;
  localparam int unsigned CHANS         = 4;
  localparam int unsigned TAG_W         = $clog2(CHANS);
  localparam int unsigned LINE_SEL_BASE = 16;
  localparam int unsigned ROUTE_W       = LINE_SEL_BASE + 2 * CHANS;

  typedef struct packed {
    logic [LINES-1:0] fall;
    logic [LINES-1:0] rise;
  } slot_t;
endpackage

// File: rtl/pdmfe_clkgen.sv
`timescale 1ns/1ps
module pdmfe_clkgen #(
  parameter int unsigned CLK_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic pdm_clk_o,
  output logic rise_evt_o,
  output logic fall_evt_o
);
  localparam int unsigned HALF  = CLK_DIV / 2;
  localparam int unsigned CNT_W = $clog2(CLK_DIV);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             clk_q, clk_d;
  logic             at_mid, at_end;

  always_comb begin
    at_mid = (cnt_q == CNT_W'(HALF - 1));
    at_end = (cnt_q == CNT_W'(CLK_DIV - 1));
    cnt_d  = at_end ? '0 : cnt_q + CNT_W'(1);
    clk_d  = clk_q;
    if (at_mid)      clk_d = 1'b1;
    else if (at_end) clk_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  assign pdm_clk_o  = clk_q;
  assign rise_evt_o = at_mid;
  assign fall_evt_o = at_end;
endmodule

// File: rtl/pdmfe_capture.sv
`timescale 1ns/1ps
module pdmfe_capture
  import pdmfe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_evt_i,
  input  logic             fall_evt_i,
  input  logic [LINES-1:0] line_i,
  output slot_t            slot_o
);
  logic [LINES-1:0] rise_q, rise_d;
  logic [LINES-1:0] fall_q, fall_d;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_comb begin
      rise_d[l] = rise_evt_i ? line_i[l] : rise_q[l];
      fall_d[l] = fall_evt_i ? line_i[l] : fall_q[l];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rise_q[l] <= 1'b0;
        fall_q[l] <= 1'b0;
      end else begin
        rise_q[l] <= rise_d[l];
        fall_q[l] <= fall_d[l];
      end
    end
  end

  assign slot_o.rise = rise_q;
  assign slot_o.fall = fall_q;
endmodule

// File: rtl/pdmfe_chan_out.sv
`timescale 1ns/1ps
module pdmfe_chan_out
  import pdmfe_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  slot_t                  slot_i,
  input  logic [CHANS-1:0]       en_i,
  input  logic [ROUTE_W-1:0]     route_i,
  output logic [CHANS-1:0]       bit_o,
  output logic [CHANS-1:0]       vld_o,
  output logic [CHANS*TAG_W-1:0] tag_o
);
  logic [CHANS-1:0]       bit_q, bit_d;
  logic [CHANS-1:0]       vld_q, vld_d;
  logic [CHANS*TAG_W-1:0] tag_q, tag_d;
  logic                   unused_route_bits;

  assign unused_route_bits = ^route_i;

  for (genvar n = 0; n < CHANS; n++) begin : g_chan
    localparam int unsigned EDGE_IDX = 2 * n;
    localparam int unsigned LINE_IDX = LINE_SEL_BASE + 2 * n;
    logic edge_sel, line_sel, pick;

    always_comb begin
      edge_sel = route_i[EDGE_IDX];
      line_sel = route_i[LINE_IDX];
      pick     = edge_sel ? slot_i.fall[line_sel] : slot_i.rise[line_sel];
      vld_d[n] = load_i & en_i[n];
      bit_d[n] = vld_d[n] & pick;
      tag_d[n*TAG_W +: TAG_W] = vld_d[n] ? TAG_W'(n) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      vld_q <= '0;
      tag_q <= '0;
    end else begin
      bit_q <= bit_d;
      vld_q <= vld_d;
      tag_q <= tag_d;
    end
  end

  assign bit_o = bit_q;
  assign vld_o = vld_q;
  assign tag_o = tag_q;
endmodule

// File: rtl/pdm_dual_edge_rx.sv
`timescale 1ns/1ps
module pdm_dual_edge_rx
  import pdmfe_pkg::*;
#(
  parameter int unsigned CLK_DIV = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LINES-1:0]       pdm_dat_i,
  input  logic [CHANS-1:0]       cfg_en_i,
  input  logic [ROUTE_W-1:0]     cfg_route_i,
  output logic                   pdm_clk_o,
  output logic [CHANS-1:0]       ch_bit_o,
  output logic [CHANS-1:0]       ch_vld_o,
  output logic [CHANS*TAG_W-1:0] ch_tag_o
);
  logic  rise_evt, fall_evt;
  slot_t slot;

  pdmfe_clkgen #(.CLK_DIV(CLK_DIV)) clkgen_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pdm_clk_o  (pdm_clk_o),
    .rise_evt_o (rise_evt),
    .fall_evt_o (fall_evt)
  );

  pdmfe_capture capture_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_evt_i (rise_evt),
    .fall_evt_i (fall_evt),
    .line_i     (pdm_dat_i),
    .slot_o     (slot)
  );

  pdmfe_chan_out chan_out_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (rise_evt),
    .slot_i  (slot),
    .en_i    (cfg_en_i),
    .route_i (cfg_route_i),
    .bit_o   (ch_bit_o),
    .vld_o   (ch_vld_o),
    .tag_o   (ch_tag_o)
  );
endmodule

// File: rtl/pdm_dual_edge_rx_chk.sv
`timescale 1ns/1ps
module pdm_dual_edge_rx_chk
  import pdmfe_pkg::*;
#(
  parameter int unsigned CLK_DIV = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [CHANS-1:0]       cfg_en_i,
  input logic [ROUTE_W-1:0]     cfg_route_i,
  input logic                   pdm_clk_o,
  input logic [CHANS-1:0]       ch_bit_o,
  input logic [CHANS-1:0]       ch_vld_o,
  input logic [CHANS*TAG_W-1:0] ch_tag_o
);
  localparam int unsigned HALF  = CLK_DIV / 2;
  localparam int unsigned CNT_W = $clog2(CLK_DIV);

  logic [CNT_W-1:0] ref_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_cnt <= '0;
    else        ref_cnt <= (ref_cnt == CNT_W'(CLK_DIV - 1)) ? '0 : ref_cnt + CNT_W'(1);
  end

  // R2
  pdm_clk_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdm_clk_o == (ref_cnt >= CNT_W'(HALF)));

  // R5
  strobe_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_vld_o) |-> $rose(pdm_clk_o));

  // R7
  vld_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_vld_o) |-> ((ch_vld_o & ~$past(cfg_en_i)) == '0));

  // R9
  bit_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_bit_o & ~ch_vld_o) == '0);

  // R6
  same_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_vld_o[0] && ch_vld_o[1] &&
     $past(cfg_route_i[0]) == $past(cfg_route_i[2]) &&
     $past(cfg_route_i[LINE_SEL_BASE]) == $past(cfg_route_i[LINE_SEL_BASE + 2]))
    |-> (ch_bit_o[0] == ch_bit_o[1]));

  for (genvar n = 0; n < CHANS; n++) begin : g_tag
    // R9
    tag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_tag_o[n*TAG_W +: TAG_W] == (ch_vld_o[n] ? TAG_W'(n) : TAG_W'(0)));
  end
endmodule

bind pdm_dual_edge_rx pdm_dual_edge_rx_chk #(.CLK_DIV(CLK_DIV)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_en_i    (cfg_en_i),
  .cfg_route_i (cfg_route_i),
  .pdm_clk_o   (pdm_clk_o),
  .ch_bit_o    (ch_bit_o),
  .ch_vld_o    (ch_vld_o),
  .ch_tag_o    (ch_tag_o)
);

// File: tb/pdm_dual_edge_rx_tb_top.sv
`timescale 1ns/1ps
module pdm_dual_edge_rx_tb_top;
  logic        clk;
  logic        rst_n;
  logic [1:0]  pdm_dat;
  logic [3:0]  cfg_en;
  logic [23:0] cfg_route;
  logic        pdm_clk;
  logic [3:0]  ch_bit;
  logic [3:0]  ch_vld;
  logic [7:0]  ch_tag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic       was_hi, new_frame;
  logic [1:0] rcur, fcur, rold, fold, exp_r, exp_f;
  logic [7:0] lfsr;

  pdm_dual_edge_rx #(.CLK_DIV(16)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pdm_dat_i   (pdm_dat),
    .cfg_en_i    (cfg_en),
    .cfg_route_i (cfg_route),
    .pdm_clk_o   (pdm_clk),
    .ch_bit_o    (ch_bit),
    .ch_vld_o    (ch_vld),
    .ch_tag_o    (ch_tag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic gen(output logic [1:0] v);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    v = lfsr[1:0];
  endtask

  // One core cycle: mic model drives the slot for the current clock phase.
  task automatic tick();
    logic hi;
    @(negedge clk);
    new_frame = 1'b0;
    hi = pdm_clk;
    if (hi && !was_hi) begin
      new_frame = 1'b1;
      exp_r = rold;
      exp_f = fold;
      rold  = rcur;
      gen(fcur);
    end else if (!hi && was_hi) begin
      fold = fcur;
      gen(rcur);
    end
    pdm_dat = hi ? fcur : rcur;
    was_hi  = hi;
  endtask

  function automatic logic exp_bit(input int n);
    logic e, l;
    e = cfg_route[2*n];
    l = cfg_route[16 + 2*n];
    return e ? exp_f[l] : exp_r[l];
  endfunction

  task automatic check_frame(input string req);
    do tick(); while (!new_frame);
    for (int n = 0; n < 4; n++) begin
      logic ev, eb;
      ev = cfg_en[n];
      eb = ev & exp_bit(n);
      chk(ch_vld[n] == ev, req, $sformatf("ch%0d valid", n), ch_vld[n], ev);
      chk(ch_bit[n] == eb, req, $sformatf("ch%0d bit", n), ch_bit[n], eb);
      // R9
      chk(ch_tag[2*n +: 2] == (ev ? n[1:0] : 2'd0), "R9", $sformatf("ch%0d tag", n),
          ch_tag[2*n +: 2], ev ? n : 0);
    end
    tick();
    // R5: strobe lasts one cycle; R9 bits drop with it
    chk(ch_vld == 4'd0, "R5", "valid after strobe", ch_vld, 0);
    chk(ch_bit == 4'd0, "R9", "bits after strobe", ch_bit, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pdm_dat = '0; cfg_en = '0; cfg_route = '0;
    lfsr = 8'hA5; was_hi = 1'b0; new_frame = 1'b0;
    rold = '0; fold = '0; fcur = '0; rcur = '0;
    repeat (4) @(negedge clk);
    // R1
    chk(pdm_clk == 1'b0, "R1", "pdm_clk in reset", pdm_clk, 0);
    chk(ch_vld == 4'd0, "R1", "valid in reset", ch_vld, 0);
    chk(ch_bit == 4'd0, "R1", "bits in reset", ch_bit, 0);
    chk(ch_tag == 8'd0, "R1", "tags in reset", ch_tag, 0);
    gen(rcur);
    pdm_dat = rcur;
    rst_n = 1'b1;
  endtask

  task automatic t_clock();
    int lo_len, hi_len;
    lo_len = 1; // release negedge is the first low cycle
    tick();
    while (!pdm_clk) begin lo_len++; tick(); end
    hi_len = 0;
    while (pdm_clk) begin hi_len++; tick(); end
    // R2
    chk(lo_len == 8, "R2", "first low phase length", lo_len, 8);
    chk(hi_len == 8, "R2", "high phase length", hi_len, 8);
    lo_len = 0;
    while (!pdm_clk) begin lo_len++; tick(); end
    chk(lo_len == 8, "R2", "low phase length", lo_len, 8);
  endtask

  task automatic t_identity();
    cfg_en = 4'hF; cfg_route = 24'h500044;
    for (int i = 0; i < 5; i++) check_frame("R3");
  endtask

  task automatic t_crossbar();
    cfg_route = 24'h050011;
    for (int i = 0; i < 5; i++) check_frame("R4");
  endtask

  task automatic t_duplicate();
    cfg_route = 24'h550055;
    for (int i = 0; i < 4; i++) begin
      check_frame("R6");
    end
    do tick(); while (!new_frame);
    chk(ch_bit == {4{exp_f[1]}}, "R6", "shared source bits", ch_bit, {4{exp_f[1]}});
  endtask

  task automatic t_ignore();
    cfg_route = 24'h500044 | 24'hAAFFAA;
    for (int i = 0; i < 4; i++) check_frame("R10");
  endtask

  task automatic t_enable();
    cfg_route = 24'h500044;
    cfg_en = 4'b0101;
    for (int i = 0; i < 3; i++) check_frame("R7");
    cfg_en = 4'b1111;
    check_frame("R8");
    cfg_en = 4'b0000;
    check_frame("R7");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_clock();
    t_identity();
    t_crossbar();
    t_duplicate();
    t_ignore();
    t_enable();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule